// File: doc/BRIEF.md
# Probe Trigger Comparator

This block is the trigger stage of an on-chip logic analyzer. Four probe inputs are watched: three single-bit probes and one multi-bit probe, four bits wide by default. Each probe has a 16-bit operation-code register and a 16-bit argument register on a memory-mapped register bus. On every clock the block tests each probe against its argument using the selected operation. The results of the enabled probes are ORed into one registered trigger output, which a capture sequencer elsewhere can use.

The register bus is a chained request/response path. A request enters on the input port and leaves on the output port one clock later, so several blocks can be strung along one bus. When a read hits one of this block's registers, the block puts that register's value in the read-data field on the way through. Every other field, and every request outside the block's range, passes through unchanged.

Top module: `probe_trig_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `valid_o`, `rw_o`, `addr_o`, `wdata_o`, `rdata_o` and `trig_o` are 0, and all eight configuration registers read back as 0.
- R2: Registers sit at addresses 3 to 10. Address 3+2k is the operation code of probe k and 4+2k is its argument. Probe order is k=0 `probe_a`, 1 `probe_b`, 2 `probe_c`, 3 `probe_d`. Every register reads back all 16 bits last written to it.
- R3: A request with `valid_i` high and an address outside 3..10 appears unchanged on the output port one cycle later, including `rdata`, and changes no register.
- R4: An in-range request is forwarded one cycle later with `addr`, `wdata`, `rw` and `valid` unchanged. A read (`rw_i`=0) returns the addressed register on `rdata_o`. A write (`rw_i`=1) passes `rdata_i` through and updates the register.
- R5: With `valid_i` low, the request fields are still forwarded, but no register changes, even if `rw_i` is 1 and the address is in range.
- R6: Operation code 0 disables a probe, and so does any code above 8. A disabled probe never contributes to the trigger.
- R7: Code 8 is true when the probe equals its argument. Code 7 is true when they differ.
- R8: Code 3 tests less-than, 4 less-or-equal, 5 greater-or-equal and 6 greater-than, always probe against argument and unsigned.
- R9: Before comparison, the argument is truncated to the probe's width. For example, 0x13 on the 4-bit probe acts as 3, and 2 on a 1-bit probe acts as 0.
- R10: Code 1 (rise) is true when the probe value is greater than its value on the previous cycle. Code 2 (fall) is true when it is smaller. The argument is ignored, and the previous value is 0 after reset.
- R11: `trig_o` is the OR of all enabled probes' results. It is registered, so it reflects the probe values and configuration of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_a | input | 1 | Single-bit probe 0 |
| probe_b | input | 1 | Single-bit probe 1 |
| probe_c | input | 1 | Single-bit probe 2 |
| probe_d | input | WIDE_W | Multi-bit probe 3 |
| addr_i | input | AW | Incoming request address |
| wdata_i | input | DW | Incoming write data |
| rdata_i | input | DW | Incoming read data from upstream |
| rw_i | input | 1 | Incoming direction, 1 = write |
| valid_i | input | 1 | Incoming request strobe |
| addr_o | output | AW | Forwarded address |
| wdata_o | output | DW | Forwarded write data |
| rdata_o | output | DW | Forwarded or filled-in read data |
| rw_o | output | 1 | Forwarded direction |
| valid_o | output | 1 | Forwarded request strobe |
| trig_o | output | 1 | Registered trigger |

## Verification
The bench builds the block with its default parameters: register base 3, 16-bit bus and a 4-bit wide probe. With a 4-bit probe, every value the probe can take is swept against each ordered comparison, and the edge operations are driven through increases, decreases and repeated values. With the default base, the bench can place requests just below and just above the register window, at addresses 2 and 11, and at the top of the address space. A behavioural model compares the trigger and every forwarded bus field against the design on every clock.

// File: rtl/ptrig_pkg.sv
`timescale 1ns/1ps
package ptrig_pkg;
  localparam int BUS_W    = 16;
  localparam int OPC_OFF  = 0;
  localparam int OPC_RISE = 1;
  localparam int OPC_FALL = 2;
  localparam int OPC_LT   = 3;
  localparam int OPC_LE   = 4;
  localparam int OPC_GE   = 5;
  localparam int OPC_GT   = 6;
  localparam int OPC_NE   = 7;
  localparam int OPC_EQ   = 8;
  localparam int OPC_MAX  = 8;
endpackage

// File: rtl/ptrig_cmp.sv
`timescale 1ns/1ps
module ptrig_cmp #(
  parameter int PW = 1,
  parameter int DW = ptrig_pkg::BUS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] probe,
  input  logic [DW-1:0] op,
  input  logic [DW-1:0] arg,
  output logic          hit
);
  import ptrig_pkg::*;

  logic [PW-1:0] prev_q;
  logic [PW-1:0] arg_t;

  assign arg_t = PW'(arg);

  // previous sample for edge operations
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= probe;
  end

  always_comb begin
    case (op)
      DW'(OPC_OFF):  hit = 1'b0;
      DW'(OPC_RISE): hit = (probe > prev_q);
      DW'(OPC_FALL): hit = (probe < prev_q);
      DW'(OPC_LT):   hit = (probe < arg_t);
      DW'(OPC_LE):   hit = (probe <= arg_t);
      DW'(OPC_GE):   hit = (probe >= arg_t);
      DW'(OPC_GT):   hit = (probe > arg_t);
      DW'(OPC_NE):   hit = (probe != arg_t);
      DW'(OPC_EQ):   hit = (probe == arg_t);
      default:       hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptrig_regbank.sv
`timescale 1ns/1ps
module ptrig_regbank #(
  parameter int AW       = 16,
  parameter int DW       = ptrig_pkg::BUS_W,
  parameter int REG_BASE = 3,
  parameter int NREG     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW-1:0]      rdata_i,
  input  logic               rw_i,
  input  logic               valid_i,
  output logic [AW-1:0]      addr_o,
  output logic [DW-1:0]      wdata_o,
  output logic [DW-1:0]      rdata_o,
  output logic               rw_o,
  output logic               valid_o,
  output logic [NREG*DW-1:0] cfg_q
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0]    regs [NREG];
  logic             in_rng;
  logic [IDX_W-1:0] idx;

  assign in_rng = (addr_i >= AW'(REG_BASE)) && (addr_i < AW'(REG_BASE + NREG));
  assign idx    = IDX_W'(addr_i - AW'(REG_BASE));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
      rw_o    <= 1'b0;
      valid_o <= 1'b0;
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      rw_o    <= rw_i;
      valid_o <= valid_i;
      if (valid_i && in_rng && !rw_i) rdata_o <= regs[idx];
      else                            rdata_o <= rdata_i;
      if (valid_i && in_rng && rw_i)  regs[idx] <= wdata_i;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_flat
    assign cfg_q[k*DW +: DW] = regs[k];
  end
endmodule

// File: rtl/probe_trig_unit.sv
`timescale 1ns/1ps
module probe_trig_unit #(
  parameter int AW       = 16,
  parameter int DW       = ptrig_pkg::BUS_W,
  parameter int WIDE_W   = 4,
  parameter int REG_BASE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              probe_a,
  input  logic              probe_b,
  input  logic              probe_c,
  input  logic [WIDE_W-1:0] probe_d,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     rdata_i,
  input  logic              rw_i,
  input  logic              valid_i,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     wdata_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rw_o,
  output logic              valid_o,
  output logic              trig_o
);
  localparam int NPROBE = 4;
  localparam int NREG   = 2 * NPROBE;

  logic [NREG*DW-1:0] cfg_q;
  logic [NPROBE-1:0]  hits;

  ptrig_regbank #(.AW(AW), .DW(DW), .REG_BASE(REG_BASE), .NREG(NREG)) u_regs (
    .clk(clk), .rst(rst),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_i(rdata_i), .rw_i(rw_i), .valid_i(valid_i),
    .addr_o(addr_o), .wdata_o(wdata_o), .rdata_o(rdata_o), .rw_o(rw_o), .valid_o(valid_o),
    .cfg_q(cfg_q)
  );

  for (genvar i = 0; i < NPROBE; i++) begin : g_probe
    localparam int PW = (i == NPROBE - 1) ? WIDE_W : 1;
    logic [PW-1:0] pv;
    if (i == 0) begin : g_sa
      assign pv = probe_a;
    end else if (i == 1) begin : g_sb
      assign pv = probe_b;
    end else if (i == 2) begin : g_sc
      assign pv = probe_c;
    end else begin : g_sd
      assign pv = probe_d;
    end
    ptrig_cmp #(.PW(PW), .DW(DW)) u_cmp (
      .clk(clk), .rst(rst), .probe(pv),
      .op(cfg_q[(2*i)*DW +: DW]), .arg(cfg_q[(2*i+1)*DW +: DW]),
      .hit(hits[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) trig_o <= 1'b0;
    else     trig_o <= |hits;
  end
endmodule

// File: rtl/ptrig_checker.sv
`timescale 1ns/1ps
module ptrig_checker #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int REG_BASE = 3,
  parameter int NPROBE   = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [AW-1:0]          addr_i,
  input logic [DW-1:0]          rdata_i,
  input logic                   valid_i,
  input logic [AW-1:0]          addr_o,
  input logic [DW-1:0]          rdata_o,
  input logic                   valid_o,
  input logic                   trig_o,
  input logic [2*NPROBE*DW-1:0] cfg_q
);
  localparam int NREG = 2 * NPROBE;

  logic in_rng;
  logic any_on;

  assign in_rng = (addr_i >= AW'(REG_BASE)) && (addr_i < AW'(REG_BASE + NREG));

  always_comb begin
    any_on = 1'b0;
    for (int i = 0; i < NPROBE; i++) begin
      if ((cfg_q[(2*i)*DW +: DW] != '0) && (cfg_q[(2*i)*DW +: DW] <= DW'(ptrig_pkg::OPC_MAX)))
        any_on = 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && !trig_o && rdata_o == '0)); // R1
  AST_VALID_FWD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (valid_o == $past(valid_i))); // R4
  AST_ADDR_FWD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(valid_i)) |-> (addr_o == $past(addr_i))); // R3
  AST_OOR_RDATA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(valid_i && !in_rng)) |-> (rdata_o == $past(rdata_i))); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(valid_i)) |-> (cfg_q == $past(cfg_q))); // R5
  AST_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(any_on)) |-> !trig_o); // R6
endmodule

bind probe_trig_unit ptrig_checker #(.AW(AW), .DW(DW), .REG_BASE(REG_BASE), .NPROBE(4)) u_chk (
  .clk(clk), .rst(rst), .addr_i(addr_i), .rdata_i(rdata_i), .valid_i(valid_i),
  .addr_o(addr_o), .rdata_o(rdata_o), .valid_o(valid_o), .trig_o(trig_o), .cfg_q(cfg_q)
);

// File: tb/tb_probe_trig_unit.sv
`timescale 1ns/1ps
module tb_probe_trig_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        probe_a = 0, probe_b = 0, probe_c = 0;
  logic [3:0]  probe_d = 0;
  logic [15:0] addr_i = 0, wdata_i = 0, rdata_i = 0;
  logic        rw_i = 0, valid_i = 0;
  logic [15:0] addr_o, wdata_o, rdata_o;
  logic        rw_o, valid_o, trig_o;

  int    nchecks = 0;
  int    nfail   = 0;
  string cur_req = "R1";
  bit    mon_en  = 0;

  // 50 MHz
  always #10 clk = ~clk;

  probe_trig_unit dut (
    .clk(clk), .rst(rst), .probe_a(probe_a), .probe_b(probe_b), .probe_c(probe_c), .probe_d(probe_d),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_i(rdata_i), .rw_i(rw_i), .valid_i(valid_i),
    .addr_o(addr_o), .wdata_o(wdata_o), .rdata_o(rdata_o), .rw_o(rw_o), .valid_o(valid_o),
    .trig_o(trig_o)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   mregs [8];
  int   prevv [4];
  int   curv  [4];
  int   widths [4] = '{1, 1, 1, 4};
  int   t_any;
  logic e_valid, e_rw, e_trig;
  logic [15:0] e_addr, e_wdata, e_rdata;

  function automatic bit mhit(int op, int arg, int cur, int prv, int w);
    int a;
    a = arg & ((1 << w) - 1);
    case (op)
      1: return cur > prv;
      2: return cur < prv;
      3: return cur < a;
      4: return cur <= a;
      5: return cur >= a;
      6: return cur > a;
      7: return cur != a;
      8: return cur == a;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 8; k++) mregs[k] = 0;
      for (int k = 0; k < 4; k++) prevv[k] = 0;
      e_valid = 0; e_rw = 0; e_trig = 0; e_addr = 0; e_wdata = 0; e_rdata = 0;
    end else begin
      curv[0] = probe_a; curv[1] = probe_b; curv[2] = probe_c; curv[3] = probe_d;
      t_any = 0;
      for (int k = 0; k < 4; k++)
        if (mhit(mregs[2*k], mregs[2*k+1], curv[k], prevv[k], widths[k])) t_any = 1;
      e_trig = (t_any != 0);
      for (int k = 0; k < 4; k++) prevv[k] = curv[k];
      e_valid = valid_i; e_rw = rw_i; e_addr = addr_i; e_wdata = wdata_i; e_rdata = rdata_i;
      if (valid_i && addr_i >= 3 && addr_i <= 10) begin
        if (rw_i) mregs[addr_i - 3] = wdata_i;
        else      e_rdata = mregs[addr_i - 3][15:0];
      end
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      chk(trig_o === e_trig, cur_req, "trig_o", trig_o, e_trig);
      chk({valid_o, rw_o, addr_o, wdata_o, rdata_o} === {e_valid, e_rw, e_addr, e_wdata, e_rdata},
          cur_req, "bus_out", {valid_o, rw_o, addr_o, wdata_o, rdata_o},
          {e_valid, e_rw, e_addr, e_wdata, e_rdata});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic access(int a, int wd, bit rw, bit v, int rdi, output int rdo);
    @(posedge clk); #5;
    addr_i = a[15:0]; wdata_i = wd[15:0]; rw_i = rw; valid_i = v; rdata_i = rdi[15:0];
    @(posedge clk); #5;
    rdo = rdata_o;
    valid_i = 0; rw_i = 0;
  endtask

  task automatic wr(int a, int d);
    int r;
    access(a, d, 1'b1, 1'b1, 16'h5A5A, r);
  endtask

  task automatic rdchk(int a, int exp, string req);
    int r;
    access(a, 0, 1'b0, 1'b1, 16'hC3C3, r);
    chk(r == exp, req, "readback", r, exp);
  endtask

  task automatic setp(bit a, bit b, bit c, int d);
    @(posedge clk); #5;
    probe_a = a; probe_b = b; probe_c = c; probe_d = d[3:0];
  endtask

  task automatic cfg(int k, int op, int arg);
    wr(3 + 2*k, op);
    wr(4 + 2*k, arg);
  endtask

  task automatic sweep_d();
    for (int v = 0; v < 16; v++) setp(0, 0, 0, v);
    for (int v = 15; v >= 0; v--) setp(0, 0, 0, v);
  endtask

  task automatic all_off();
    for (int k = 0; k < 4; k++) cfg(k, 0, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int r;
    @(posedge clk); #1; mon_en = 1;
    repeat (4) @(posedge clk);
    #5;
    // R1: outputs quiet under reset
    chk(valid_o == 0 && trig_o == 0 && rdata_o == 0 && addr_o == 0, "R1", "reset_outputs",
        {valid_o, trig_o, rdata_o}, 0);
    rst = 0;
    @(posedge clk); #5;
    chk(valid_o == 0 && trig_o == 0, "R1", "first_cycle", {valid_o, trig_o}, 0);
    for (int k = 0; k < 8; k++) rdchk(3 + k, 0, "R1");

    cur_req = "R2";
    for (int k = 0; k < 8; k++) wr(3 + k, (k * 16'h2345 + 16'h0F0F) & 16'hFFFF);
    for (int k = 0; k < 8; k++) rdchk(3 + k, (k * 16'h2345 + 16'h0F0F) & 16'hFFFF, "R2");
    for (int k = 0; k < 8; k++) begin wr(3 + k, 16'hFFFF); rdchk(3 + k, 16'hFFFF, "R2"); end
    for (int k = 0; k < 8; k++) begin wr(3 + k, 0); rdchk(3 + k, 0, "R2"); end

    cur_req = "R3";
    wr(2, 16'h1111); wr(11, 16'h2222); wr(0, 16'h3333); wr(16'hFFFF, 16'h4444);
    access(2, 0, 1'b0, 1'b1, 16'h1234, r);
    chk(r == 16'h1234, "R3", "oor_read_addr2", r, 16'h1234);
    access(11, 0, 1'b0, 1'b1, 16'hABCD, r);
    chk(r == 16'hABCD, "R3", "oor_read_addr11", r, 16'hABCD);
    for (int k = 0; k < 8; k++) rdchk(3 + k, 0, "R3");

    cur_req = "R4";
    access(5, 16'h00AB, 1'b1, 1'b1, 16'h5A5A, r);
    chk(r == 16'h5A5A, "R4", "write_passes_rdata", r, 16'h5A5A);
    access(5, 0, 1'b0, 1'b1, 16'hBEEF, r);
    chk(r == 16'h00AB, "R4", "read_fills_rdata", r, 16'h00AB);
    wr(5, 0);

    cur_req = "R5";
    wr(3, 16'h0042);
    access(3, 16'h0077, 1'b1, 1'b0, 0, r);
    access(10, 16'h0077, 1'b1, 1'b0, 0, r);
    rdchk(3, 16'h0042, "R5");
    rdchk(10, 0, "R5");
    wr(3, 0);

    cur_req = "R6";
    setp(1, 1, 1, 15); setp(0, 0, 0, 0); setp(1, 1, 1, 15);
    @(posedge clk); #5;
    chk(trig_o == 0, "R6", "all_op0", trig_o, 0);
    for (int k = 0; k < 4; k++) cfg(k, 9 + k * 16'h3FFF, 0);
    setp(0, 0, 0, 0); setp(1, 1, 1, 15); setp(0, 1, 0, 3);
    @(posedge clk); #5;
    chk(trig_o == 0, "R6", "ops_above_8", trig_o, 0);
    all_off();

    cur_req = "R7";
    cfg(3, 8, 9); sweep_d();
    cfg(3, 7, 9); sweep_d();
    cfg(3, 0, 0);
    cfg(1, 8, 1);
    setp(0, 0, 0, 0); setp(0, 1, 0, 0); setp(0, 1, 0, 0); setp(0, 0, 0, 0);
    cfg(1, 0, 0);

    cur_req = "R8";
    for (int op = 3; op <= 6; op++) begin cfg(3, op, 6); sweep_d(); end
    cfg(3, 6, 0); sweep_d();
    cfg(3, 3, 15); sweep_d();
    cfg(3, 0, 0);
    cfg(2, 6, 0);
    setp(0, 0, 1, 0); setp(0, 0, 0, 0); setp(0, 0, 1, 0);
    cfg(2, 0, 0);

    cur_req = "R9";
    cfg(3, 8, 16'h0013); sweep_d();
    cfg(3, 6, 16'hFFF2); sweep_d();
    cfg(3, 0, 0);
    cfg(0, 8, 2);
    setp(1, 0, 0, 0); setp(0, 0, 0, 0);
    @(posedge clk); #5;
    chk(trig_o == 1, "R9", "arg2_is_0_on_bit", trig_o, 1);
    setp(1, 0, 0, 0);
    @(posedge clk); #5;
    chk(trig_o == 0, "R9", "arg2_not_1_on_bit", trig_o, 0);
    cfg(0, 0, 0);

    cur_req = "R10";
    cfg(3, 1, 16'h000F);
    foreach (widths[j]) begin end
    setp(0, 0, 0, 0); setp(0, 0, 0, 3); setp(0, 0, 0, 3); setp(0, 0, 0, 7);
    setp(0, 0, 0, 2); setp(0, 0, 0, 2); setp(0, 0, 0, 15); setp(0, 0, 0, 0);
    cfg(3, 2, 0);
    setp(0, 0, 0, 0); setp(0, 0, 0, 9); setp(0, 0, 0, 4); setp(0, 0, 0, 4);
    setp(0, 0, 0, 12); setp(0, 0, 0, 1); setp(0, 0, 0, 0);
    cfg(3, 0, 0);
    cfg(2, 1, 1);
    setp(0, 0, 0, 0); setp(0, 0, 1, 0);
    @(posedge clk); #5;
    chk(trig_o == 1, "R10", "bit_rise", trig_o, 1);
    setp(0, 0, 1, 0);
    @(posedge clk); #5;
    chk(trig_o == 0, "R10", "bit_hold", trig_o, 0);
    cfg(2, 2, 1);
    setp(0, 0, 0, 0); setp(0, 0, 1, 0); setp(0, 0, 0, 0);
    cfg(2, 0, 0);

    cur_req = "R11";
    cfg(0, 8, 1);
    cfg(3, 6, 10);
    setp(0, 0, 0, 0);
    setp(0, 0, 0, 0);
    setp(1, 0, 0, 0);
    chk(trig_o == 0, "R11", "latency_not_yet", trig_o, 0);
    @(posedge clk); #5;
    chk(trig_o == 1, "R11", "one_cycle_later", trig_o, 1);
    setp(0, 0, 0, 12); setp(1, 0, 0, 12); setp(0, 0, 0, 4); setp(1, 0, 0, 11);
    @(posedge clk); #5;
    chk(trig_o == 1, "R11", "both_true", trig_o, 1);
    setp(0, 0, 0, 10);
    @(posedge clk); #5;
    chk(trig_o == 0, "R11", "neither_true", trig_o, 0);
    all_off();
    repeat (3) @(posedge clk);
    #5;
    finish_run();
  end
endmodule